// File: doc/BRIEF.md
# Table-Encoded Clock-Enable Divider with Source Select

This block turns one of three incoming clock-enable streams into a slower enable stream. A configuration word carries a 2-bit source select and a 3-bit ratio code. The ratio code does not count linearly. A lookup table converts it into the actual division ratio. The design parameter `GEN` picks one of four tables. Some tables have odd ratios, and in some tables codes 0 and 1 give the same ratio. The block emits a one-cycle tick each time the selected source has delivered the chosen number of enables. It also shows the ratio in force on a readback port.

Everything runs in one reference clock domain. The sources are enable pulses, not clocks. A new select or code never cuts a division period short. The settings are captured when a period starts and held until that period ends. While no period is in progress, the block follows the configuration word directly.

Top module: `ratio_table_divider`

## Requirements
- R1: Select value 0 counts `src_en_i[0]`, 1 counts `src_en_i[1]` and 2 counts `src_en_i[2]`. Enables on sources that are not selected never advance the count.
- R2: Select value 3 selects no source: `tick_o` stays 0 for as long as that select governs.
- R3: With `GEN`=0, ratio codes 0..7 decode to 2, 2, 3, 4, 5, 6, 7, 8.
- R4: With `GEN`=1 the codes decode to 4, 4, 6, 8, 10, 12, 14, 16. With `GEN`=2 they decode to 2, 4, 6, 8, 10, 12, 14, 16. With `GEN`=3 they decode to 4, 8, 12, 16, 20, 24, 28, 32.
- R5: `tick_o` pulses exactly once per N selected-source enables, where N is the decoded ratio, and is never high for two cycles in a row. This holds for odd and even N.
- R6: `tick_o` rises in the clock cycle directly after the cycle in which the N-th selected enable is sampled.
- R7: A change of select or code while a period is in progress takes effect only after that period's tick. The current period keeps its ratio and source.
- R8: `ratio_o` shows the ratio of the period in progress. When no enable of a new period has yet been counted, it shows the decoded value of the current code field in the same cycle.
- R9: During reset `tick_o` is 0 and the count is cleared. After reset is released, the first tick follows N selected enables, even if reset interrupted a partial period.
- R10: The ratio code is `cfg_word_i[CODE_LSB+2:CODE_LSB]` and the select is `cfg_word_i[SEL_LSB+1:SEL_LSB]`, with defaults 28 and 2. All other bits of the word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low reset |
| src_en_i | input | NUM_SRC (3) | Source clock-enable pulses, one bit per source |
| cfg_word_i | input | REG_W (32) | Configuration word holding the select and ratio-code fields |
| tick_o | output | 1 | Divided enable, one cycle wide |
| ratio_o | output | DIV_W (6) | Decoded division ratio now in force |

## Verification
A count that goes wrong shows up at the ports within one period: the tick is early, late, missing, or two cycles wide. A wrong captured ratio or source shows up on `ratio_o` in the next cycle of a running period. A wrong table entry shows up on `ratio_o` in the same cycle as the code is driven while the divider is idle. The bench therefore sweeps every code against every real source with noise on the other sources. It checks the tick after every single enable, so any slip is caught at the first enable where it occurs.

// File: rtl/ratio_div_pkg.sv
package ratio_div_pkg;
    localparam int CODE_W  = 3;
    localparam int SEL_W   = 2;
    localparam int MAX_DIV = 32;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic             tick;
    } div_state_t;
endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
    import ratio_div_pkg::*;
#(
    parameter int GEN = 0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [DIV_W-1:0]  ratio_o
);
    logic [DIV_W-1:0] code_ext;
    assign code_ext = DIV_W'(code_i);

    generate
        if (GEN == 0) begin : g_tab_step1
            assign ratio_o = (code_i < CODE_W'(2)) ? DIV_W'(2) : code_ext + DIV_W'(1);
        end else if (GEN == 1) begin : g_tab_step2_floor4
            assign ratio_o = (code_i < CODE_W'(2)) ? DIV_W'(4) : (code_ext << 1) + DIV_W'(2);
        end else if (GEN == 2) begin : g_tab_step2
            assign ratio_o = (code_ext << 1) + DIV_W'(2);
        end else begin : g_tab_step4
            assign ratio_o = (code_ext << 2) + DIV_W'(4);
        end
    endgenerate
endmodule

// File: rtl/src_pick.sv
module src_pick
    import ratio_div_pkg::*;
#(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);
    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SEL_W'(i)) hit_o = en_i[i];
        end
    end
endmodule

// File: rtl/div_core.sv
module div_core
    import ratio_div_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             hit_i,
    output logic [SEL_W-1:0] eff_sel_o,
    output logic [DIV_W-1:0] eff_div_o,
    output logic             tick_o
);
    div_state_t st_q, st_d;
    logic idle;

    assign idle      = (st_q.cnt == '0);
    assign eff_sel_o = idle ? cfg_sel_i : st_q.sel;
    assign eff_div_o = idle ? cfg_div_i : st_q.div;
    assign tick_o    = st_q.tick;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (idle) begin
            st_d.sel = cfg_sel_i;
            st_d.div = cfg_div_i;
        end
        if (hit_i) begin
            if (st_q.cnt + DIV_W'(1) == eff_div_o) begin
                st_d.cnt  = '0;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assert_tick_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tick |=> !st_q.tick);
    assert_tick_after_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.tick |-> $past(hit_i));
    assert_sel3_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff_sel_o == SEL_W'(3)) |=> !st_q.tick);
    assert_hold_ratio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt != '0) |-> ($stable(eff_div_o) && $stable(eff_sel_o)));
    assert_cnt_below_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < eff_div_o);
    assert_div_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_div_i >= DIV_W'(2));
endmodule

// File: rtl/ratio_table_divider.sv
module ratio_table_divider
    import ratio_div_pkg::*;
#(
    parameter int GEN      = 0,
    parameter int NUM_SRC  = 3,
    parameter int REG_W    = 32,
    parameter int SEL_LSB  = 2,
    parameter int CODE_LSB = 28
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [REG_W-1:0]   cfg_word_i,
    output logic               tick_o,
    output logic [DIV_W-1:0]   ratio_o
);
    logic [CODE_W-1:0] cfg_code;
    logic [SEL_W-1:0]  cfg_sel, eff_sel;
    logic [DIV_W-1:0]  cfg_div;
    logic              hit;
    logic              unused_cfg_bits;

    assign cfg_code        = cfg_word_i[CODE_LSB +: CODE_W];
    assign cfg_sel         = cfg_word_i[SEL_LSB +: SEL_W];
    assign unused_cfg_bits = ^cfg_word_i;

    ratio_decode #(.GEN(GEN)) u_decode (
        .code_i  (cfg_code),
        .ratio_o (cfg_div)
    );

    src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .en_i  (src_en_i),
        .sel_i (eff_sel),
        .hit_o (hit)
    );

    div_core u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cfg_sel_i (cfg_sel),
        .cfg_div_i (cfg_div),
        .hit_i     (hit),
        .eff_sel_o (eff_sel),
        .eff_div_o (ratio_o),
        .tick_o    (tick_o)
    );
endmodule

// File: tb/ratio_table_divider_tb_top.sv
module ratio_table_divider_tb_top;
    localparam int SEL_LSB  = 2;
    localparam int CODE_LSB = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_en = '0;
    logic [31:0] cfg = '0;
    logic        tick, tick_b, tick_c, tick_d;
    logic [5:0]  ratio, ratio_b, ratio_c, ratio_d;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ratio_table_divider #(.GEN(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .cfg_word_i(cfg),
        .tick_o(tick), .ratio_o(ratio));
    ratio_table_divider #(.GEN(1)) dut_b_i (
        .clk_i(clk), .rst_ni(rst_n), .src_en_i(3'b000), .cfg_word_i(cfg),
        .tick_o(tick_b), .ratio_o(ratio_b));
    ratio_table_divider #(.GEN(2)) dut_c_i (
        .clk_i(clk), .rst_ni(rst_n), .src_en_i(3'b000), .cfg_word_i(cfg),
        .tick_o(tick_c), .ratio_o(ratio_c));
    ratio_table_divider #(.GEN(3)) dut_d_i (
        .clk_i(clk), .rst_ni(rst_n), .src_en_i(3'b000), .cfg_word_i(cfg),
        .tick_o(tick_d), .ratio_o(ratio_d));

    function automatic int exp_ratio(int gen, int code);
        case (gen)
            0:       return (code <= 1) ? 2 : code + 1;
            1:       return (code <= 1) ? 4 : 2 * (code + 1);
            2:       return 2 * code + 2;
            default: return 4 * code + 4;
        endcase
    endfunction

    function automatic logic [31:0] make_cfg(int sel, int code, logic [31:0] fill);
        logic [31:0] w = fill;
        w[SEL_LSB +: 2]  = 2'(sel);
        w[CODE_LSB +: 3] = 3'(code);
        return w;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    // One full period on source sel: N hits, each followed by a gap cycle.
    task automatic run_period(int sel, int code, bit noise, logic [31:0] fill, string req);
        int n = exp_ratio(0, code);
        logic [2:0] own = 3'b001 << sel;
        logic [2:0] other = noise ? ~own : 3'b000;
        cfg = make_cfg(sel, code, fill);
        #1 chk({req, " R8 idle ratio"}, ratio, n);
        for (int k = 1; k <= n; k++) begin
            src_en = own | other;
            @(negedge clk);
            chk((k == n) ? {req, " R6 tick after last enable"} : {req, " R5 no early tick"},
                tick, (k == n) ? 1 : 0);
            src_en = other;
            @(negedge clk);
            chk({req, " R5 single-cycle tick"}, tick, 0);
        end
        src_en = '0;
    endtask

    task automatic hits(int sel, int count);
        for (int k = 0; k < count; k++) begin
            src_en = 3'b001 << sel;
            @(negedge clk);
            chk("R7 no tick inside period", tick, 0);
            src_en = '0;
            @(negedge clk);
        end
    endtask

    initial begin
        cfg = make_cfg(0, 7, '0);
        repeat (3) @(negedge clk);
        chk("R9 tick low in reset", tick, 0);
        src_en = 3'b111;
        @(negedge clk);
        chk("R9 enables ignored in reset", tick, 0);
        src_en = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R9: first tick after N enables from reset
        run_period(0, 7, 1'b0, '0, "R9 first period");

        // R1 R3 R5 R6: sweep codes and sources with noise on others
        for (int sel = 0; sel < 3; sel++)
            for (int code = 0; code < 8; code++)
                run_period(sel, code, 1'b1, '0, "R1 R3 sweep");

        // R10: all non-field bits set
        for (int code = 0; code < 8; code += 3)
            run_period(1, code, 1'b1, 32'hFFFF_FFFF, "R10 other bits set");

        // R2: select 3 never ticks
        cfg = make_cfg(3, 2, '0);
        src_en = 3'b111;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R2 select 3 quiet", tick, 0);
        end
        src_en = '0;
        @(negedge clk);

        // R7 R8: change mid-period
        cfg = make_cfg(0, 7, '0);
        hits(0, 3);
        cfg = make_cfg(1, 0, '0);
        #1 chk("R8 ratio held in period", ratio, 8);
        hits(1, 3);
        chk("R7 other source ignored in period", ratio, 8);
        hits(0, 4);
        src_en = 3'b001;
        @(negedge clk);
        chk("R7 tick at old ratio", tick, 1);
        src_en = '0;
        #1 chk("R8 ratio follows new code", ratio, 2);
        hits(0, 4);
        src_en = 3'b010;
        @(negedge clk);
        src_en = '0;
        @(negedge clk);
        src_en = 3'b010;
        @(negedge clk);
        chk("R7 new source and ratio", tick, 1);
        src_en = '0;
        @(negedge clk);

        // R9: reset interrupts a partial period
        cfg = make_cfg(2, 4, '0);
        hits(2, 3);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 tick low after reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_period(2, 4, 1'b0, '0, "R9 restart");

        // R3 R4: table readback for all variants while idle
        for (int code = 0; code < 8; code++) begin
            cfg = make_cfg(0, code, '0);
            #1;
            chk("R3 table GEN0", ratio, exp_ratio(0, code));
            chk("R4 table GEN1", ratio_b, exp_ratio(1, code));
            chk("R4 table GEN2", ratio_c, exp_ratio(2, code));
            chk("R4 table GEN3", ratio_d, exp_ratio(3, code));
            @(negedge clk);
        end
        chk("R4 idle variants quiet", int'(tick_b | tick_c | tick_d), 0);

        finish_run();
    end
endmodule